// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order core that executes a three-instruction subset: register add, load word and store word. Each instruction moves through five stages: fetch, register read with decode, address or sum computation, data memory access, and register write. A new instruction enters every cycle and one leaves every cycle. There is no stall logic, no branch logic and no hazard detection beyond a single forwarding path.

The add instruction does no work in the memory stage, but it still passes through it. This keeps its register write in the fifth stage, the same stage as a load. As a result the single write port of the register file is never wanted by two instructions in one cycle.

Both memories are synchronous and sit outside the block. The block presents an address in one cycle and uses the data in the next. The register-file write port is brought out to the pins so that retired results can be observed.

The register file forwards a value that is being written to a read of the same register in the same cycle. A consumer therefore needs at least two instructions between itself and its producer. The program, or whatever feeds the program, must enforce that spacing, and the core does not check it.

Top module: `pipe5_core`

## Requirements
- R1: After reset the fetch address is 0. It increases by 4 on every clock edge. The instruction memory returns the word for an address one cycle after that address is presented.
- R2: The add instruction has bits [31:26] = 0, bits [10:6] = 0 and bits [5:0] = 0x20, with source fields at [25:21] and [20:16] and destination at [15:11]. It writes the 32-bit wrapped sum of the two sources to the destination. The write is visible on the write-back pins in the fourth cycle after the edge that latched the instruction into decode.
- R3: Load (bits [31:26] = 0x23) forms its address as the base register at [25:21] plus the sign-extended 16-bit offset in [15:0]. It asserts the read strobe in the memory stage and writes the returned word to the register at [20:16] in the next cycle.
- R4: Store (bits [31:26] = 0x2B) asserts the write strobe for one cycle in the memory stage. The address is formed as for a load, and the data is the register at [20:16]. The read and write strobes are never high together.
- R5: Every instruction retires in stage five. Consecutive instructions retire on consecutive cycles, so there is at most one register write per cycle.
- R6: Register 0 always reads as zero. A write that targets register 0 is dropped, and the write-back valid pin stays low for it.
- R7: A register read in the same cycle as a write to that register returns the value being written. A gap of two instructions between producer and consumer is therefore enough.
- R8: Any other opcode, and an opcode-0 word whose shift field or function field does not match add, is a no-op. It causes no register write and no memory strobe.
- R9: The active-low reset acts asynchronously. It sets the fetch address to 0 and clears every stage-valid bit at once, so all strobes and the write-back valid pin drop immediately. Execution restarts from address 0 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| imem_addr | output | 32 | Instruction fetch byte address |
| imem_rdata | input | 32 | Instruction word for the address of the previous cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data for the read of the previous cycle |
| wb_valid | output | 1 | A register write happens this cycle |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |

## Verification
Results are sampled on the falling edge after rising edge e, counted from reset release. At that point the fetch address must be 4e. The memory strobes belong to instruction e-3, and the write-back pins belong to instruction e-4. The bench walks its vector table with exactly that offset and checks, on every cycle, both that the expected action happens and that no other action happens. The reset checks sample one time step after an asynchronous assert. The restart checks count the same offsets again from the new release.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam logic [5:0] OPC_REG = 6'h00;
  localparam logic [5:0] OPC_LDW = 6'h23;
  localparam logic [5:0] OPC_STW = 6'h2B;
  localparam logic [5:0] FN_ADD  = 6'h20;

  typedef enum logic [1:0] {
    OPK_NOP   = 2'd0,
    OPK_ADD   = 2'd1,
    OPK_LOAD  = 2'd2,
    OPK_STORE = 2'd3
  } opkind_e;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output opkind_e           kind_o,
  output logic [RIDX_W-1:0] rs_o,
  output logic [RIDX_W-1:0] rt_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic [XLEN-1:0]   imm_o
);
  localparam int unsigned IMM_W = 16;

  logic [5:0]        fld_op;
  logic [5:0]        fld_fn;
  logic [4:0]        fld_sh;
  logic [RIDX_W-1:0] fld_rd;
  logic [IMM_W-1:0]  fld_imm;

  always_comb begin
    fld_op  = instr_i[31:26];
    fld_fn  = instr_i[5:0];
    fld_sh  = instr_i[10:6];
    fld_rd  = instr_i[11 +: RIDX_W];
    fld_imm = instr_i[IMM_W-1:0];
    rs_o    = instr_i[21 +: RIDX_W];
    rt_o    = instr_i[16 +: RIDX_W];
    imm_o   = {{(XLEN-IMM_W){fld_imm[IMM_W-1]}}, fld_imm};
    kind_o  = OPK_NOP;
    dest_o  = '0;
    if (valid_i) begin
      unique case (fld_op)
        OPC_REG: begin
          if (fld_fn == FN_ADD && fld_sh == 5'd0) begin
            kind_o = OPK_ADD;
            dest_o = fld_rd;
          end
        end
        OPC_LDW: begin
          kind_o = OPK_LOAD;
          dest_o = rt_o;
        end
        OPC_STW: kind_o = OPK_STORE;
        default: kind_o = OPK_NOP;
      endcase
    end
  end

  // R8: words outside the subset must come out as no-ops
  p_foreign_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[31:26] != OPC_REG && instr_i[31:26] != OPC_LDW
     && instr_i[31:26] != OPC_STW) |-> kind_o == OPK_NOP);
  p_bad_fn_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OPC_REG && (instr_i[5:0] != FN_ADD || instr_i[10:6] != 5'd0))
    |-> kind_o == OPK_NOP);
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRP   = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr [NRP],
  output logic [WIDTH-1:0] rdata [NRP]
);
  logic [WIDTH-1:0] store_q [DEPTH];
  logic             wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) store_q[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                       rdata[p] = '0;
      else if (wr_en && raddr[p] == waddr)      rdata[p] = wdata;
      else                                      rdata[p] = store_q[raddr[p]];
    end
  end

  // R7: a granted write lands in storage for later reads
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store_q[$past(waddr)] == $past(wdata));
  // R6: register 0 reads zero
  p_zero_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raddr[0] == '0 |-> rdata[0] == '0);
endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  opkind_e         kind_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] result_o
);
  logic [XLEN-1:0] rhs;

  always_comb begin
    rhs      = (kind_i == OPK_ADD) ? opb_i : imm_i;
    result_o = opa_i + rhs;
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NREGS   = 32,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  output logic              dmem_re,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [XLEN-1:0]   wb_data
);
  // fetch
  logic [XLEN-1:0] pc_q, pc_d;
  logic            id_valid_q;

  always_comb pc_d = pc_q + XLEN'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= '0;
      id_valid_q <= 1'b0;
    end else begin
      pc_q       <= pc_d;
      id_valid_q <= 1'b1;
    end
  end

  assign imem_addr = pc_q;

  // decode and register read
  opkind_e           dec_kind;
  logic [RIDX_W-1:0] dec_rs, dec_rt, dec_dest;
  logic [XLEN-1:0]   dec_imm;
  logic [RIDX_W-1:0] rf_raddr [2];
  logic [XLEN-1:0]   rf_rdata [2];

  pipe5_decode #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (id_valid_q),
    .instr_i (imem_rdata),
    .kind_o  (dec_kind),
    .rs_o    (dec_rs),
    .rt_o    (dec_rt),
    .dest_o  (dec_dest),
    .imm_o   (dec_imm)
  );

  always_comb begin
    rf_raddr[0] = dec_rs;
    rf_raddr[1] = dec_rt;
  end

  logic wb_valid_q;
  logic [RIDX_W-1:0] wb_dest_q;

  pipe5_regfile #(.WIDTH(XLEN), .DEPTH(NREGS), .NRP(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_valid_q),
    .waddr (wb_dest_q),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  // execute stage registers
  logic              ex_valid_q, ex_valid_d;
  opkind_e           ex_kind_q;
  logic [RIDX_W-1:0] ex_dest_q;
  logic [XLEN-1:0]   ex_opa_q, ex_opb_q, ex_imm_q;
  logic [XLEN-1:0]   ex_result;

  always_comb ex_valid_d = id_valid_q && (dec_kind != OPK_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ex_valid_q <= 1'b0;
    else        ex_valid_q <= ex_valid_d;
  end

  always_ff @(posedge clk) begin
    if (ex_valid_d) begin
      ex_kind_q <= dec_kind;
      ex_dest_q <= dec_dest;
      ex_opa_q  <= rf_rdata[0];
      ex_opb_q  <= rf_rdata[1];
      ex_imm_q  <= dec_imm;
    end
  end

  pipe5_exec #(.XLEN(XLEN)) u_exec (
    .kind_i   (ex_kind_q),
    .opa_i    (ex_opa_q),
    .opb_i    (ex_opb_q),
    .imm_i    (ex_imm_q),
    .result_o (ex_result)
  );

  // memory stage registers
  logic              mem_valid_q;
  opkind_e           mem_kind_q;
  logic [RIDX_W-1:0] mem_dest_q;
  logic [XLEN-1:0]   mem_alu_q, mem_sdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_valid_q <= 1'b0;
    else        mem_valid_q <= ex_valid_q;
  end

  always_ff @(posedge clk) begin
    if (ex_valid_q) begin
      mem_kind_q  <= ex_kind_q;
      mem_dest_q  <= ex_dest_q;
      mem_alu_q   <= ex_result;
      mem_sdata_q <= ex_opb_q;
    end
  end

  always_comb begin
    dmem_addr  = mem_alu_q;
    dmem_wdata = mem_sdata_q;
    dmem_we    = mem_valid_q && (mem_kind_q == OPK_STORE);
    dmem_re    = mem_valid_q && (mem_kind_q == OPK_LOAD);
  end

  // write-back stage registers
  logic            wb_valid_d;
  logic            wb_load_q;
  logic [XLEN-1:0] wb_alu_q;

  always_comb wb_valid_d = mem_valid_q && (mem_kind_q != OPK_STORE)
                           && (mem_dest_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_valid_q <= 1'b0;
    else        wb_valid_q <= wb_valid_d;
  end

  always_ff @(posedge clk) begin
    if (wb_valid_d) begin
      wb_load_q <= (mem_kind_q == OPK_LOAD);
      wb_dest_q <= mem_dest_q;
      wb_alu_q  <= mem_alu_q;
    end
  end

  always_comb begin
    wb_valid = wb_valid_q;
    wb_reg   = wb_dest_q;
    wb_data  = wb_load_q ? dmem_rdata : wb_alu_q;
  end

  // R1: fetch address steps once per edge
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> imem_addr == $past(imem_addr) + XLEN'(PC_STEP));
  // R4: strobes exclusive
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));
  // R5: a retirement always comes from an occupied memory stage
  p_wb_follows_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_valid_q));
  // R3: a retiring load had its read strobe one cycle earlier
  p_load_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_load_q) |-> $past(dmem_re));
  // R6: no write to register 0 reaches the pins
  p_no_r0_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_reg != '0);
  // R9: reset keeps the outputs idle
  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |-> (!dmem_we && !dmem_re && !wb_valid && imem_addr == '0));
endmodule

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam logic [1:0] E_NONE = 2'd0, E_WB = 2'd1, E_ST = 2'd2;

  typedef struct packed {
    logic [31:0] ins;
    logic [1:0]  ek;
    logic [31:0] tgt;
    logic [31:0] val;
  } vec_t;

  function automatic logic [31:0] f_add(input logic [4:0] rd, rs, rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] f_lw(input logic [4:0] rt, rs, input logic [15:0] imm);
    return {6'h23, rs, rt, imm};
  endfunction
  function automatic logic [31:0] f_sw(input logic [4:0] rt, rs, input logic [15:0] imm);
    return {6'h2B, rs, rt, imm};
  endfunction

  // program and expected retirement (register write or store) per slot
  localparam vec_t VEC [NV] = '{
    '{f_lw(5'd1, 5'd0, 16'h0000), E_WB, 32'd1, 32'h0000_0005},
    '{f_lw(5'd2, 5'd0, 16'h0004), E_WB, 32'd2, 32'h0000_0010},
    '{f_lw(5'd3, 5'd0, 16'h0008), E_WB, 32'd3, 32'hFFFF_FFF0},
    '{f_lw(5'd4, 5'd0, 16'h000C), E_WB, 32'd4, 32'h7FFF_FFFF},
    '{f_add(5'd5, 5'd1, 5'd2),    E_WB, 32'd5, 32'h0000_0015},
    '{f_add(5'd6, 5'd3, 5'd1),    E_WB, 32'd6, 32'hFFFF_FFF5},
    '{f_add(5'd0, 5'd1, 5'd1),    E_NONE, 32'd0, 32'd0},
    '{f_add(5'd7, 5'd4, 5'd4),    E_WB, 32'd7, 32'hFFFF_FFFE},
    '{f_lw(5'd8, 5'd2, 16'hFFFC), E_WB, 32'd8, 32'h7FFF_FFFF},
    '{f_sw(5'd5, 5'd0, 16'h0010), E_ST, 32'h0000_0010, 32'h0000_0015},
    '{f_add(5'd9, 5'd0, 5'd5),    E_WB, 32'd9, 32'h0000_0015},
    '{32'hFC00_0000,              E_NONE, 32'd0, 32'd0},
    '{f_sw(5'd6, 5'd3, 16'hFFF4), E_ST, 32'hFFFF_FFE4, 32'hFFFF_FFF5},
    '{f_lw(5'd10, 5'd0, 16'h0010), E_WB, 32'd10, 32'h0000_0015},
    '{{6'h00, 5'd1, 5'd2, 5'd12, 5'd0, 6'h22}, E_NONE, 32'd0, 32'd0},
    '{f_add(5'd11, 5'd6, 5'd7),   E_WB, 32'd11, 32'hFFFF_FFF3},
    '{{6'h00, 5'd1, 5'd2, 5'd13, 5'd1, 6'h20}, E_NONE, 32'd0, 32'd0},
    '{32'h0000_0000,              E_NONE, 32'd0, 32'd0},
    '{f_sw(5'd11, 5'd0, 16'h0018), E_ST, 32'h0000_0018, 32'hFFFF_FFF3},
    '{f_lw(5'd13, 5'd3, 16'hFFF4), E_WB, 32'd13, 32'hFFFF_FFF5}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic        wb_valid;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic        dm_init;
  int          checks;
  int          errors;
  bit          done;

  pipe5_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_data    (wb_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous memory models
  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[7:2]];
    if (dm_init) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 32'd0;
      dmem[0] <= 32'h0000_0005;
      dmem[1] <= 32'h0000_0010;
      dmem[2] <= 32'hFFFF_FFF0;
      dmem[3] <= 32'h7FFF_FFFF;
    end else begin
      if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:2]];
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = (i < NV) ? VEC[i].ins : 32'd0;
    rst_n   = 1'b0;
    dm_init = 1'b1;
    repeat (2) @(negedge clk);
    dm_init = 1'b0;

    // R9: idle outputs while held in reset
    chk("R9 reset fetch addr", imem_addr, 32'd0);
    chk("R9 reset wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R9 reset store strobe", {31'd0, dmem_we}, 32'd0);
    chk("R9 reset load strobe", {31'd0, dmem_re}, 32'd0);
    rst_n = 1'b1;

    // table walk: after edge e, stage 4 holds slot e-3, stage 5 holds slot e-4
    for (int e = 1; e <= NV + 5; e++) begin
      int iw;
      int is;
      step();
      iw = e - 4;
      is = e - 3;
      chk("R1 fetch address", imem_addr, 32'(4 * e));
      if (iw >= 0 && iw < NV && VEC[iw].ek == E_WB) begin
        chk("R2/R3/R7 wb_valid", {31'd0, wb_valid}, 32'd1);
        chk("R2/R3/R5 wb_reg", {27'd0, wb_reg}, VEC[iw].tgt);
        chk("R2/R3/R7 wb_data", wb_data, VEC[iw].val);
      end else begin
        chk("R5/R6/R8 no write", {31'd0, wb_valid}, 32'd0);
      end
      if (is >= 0 && is < NV && VEC[is].ek == E_ST) begin
        chk("R4 store strobe", {31'd0, dmem_we}, 32'd1);
        chk("R4 store addr", dmem_addr, VEC[is].tgt);
        chk("R4 store data", dmem_wdata, VEC[is].val);
      end else begin
        chk("R4/R8 no store", {31'd0, dmem_we}, 32'd0);
      end
      chk("R3 load strobe", {31'd0, dmem_re},
          (is >= 0 && is < NV && VEC[is].ins[31:26] == 6'h23) ? 32'd1 : 32'd0);
    end

    // R9: asynchronous reset, then restart from address 0
    rst_n = 1'b0;
    #1;
    chk("R9 async fetch addr", imem_addr, 32'd0);
    chk("R9 async wb_valid", {31'd0, wb_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      step();
      if (e <= 3) chk("R9 empty pipe after restart", {31'd0, wb_valid}, 32'd0);
      if (e == 3) chk("R9 restart first load strobe", {31'd0, dmem_re}, 32'd1);
      if (e == 4) begin
        chk("R9 restart first write reg", {27'd0, wb_reg}, 32'd1);
        chk("R9 restart first write data", wb_data, 32'h0000_0005);
      end
      if (e == 12) begin
        chk("R4 restart store strobe", {31'd0, dmem_we}, 32'd1);
        chk("R4 restart store addr", dmem_addr, 32'h0000_0010);
      end
    end
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R9 store dropped by async reset", {31'd0, dmem_we}, 32'd0);
    chk("R9 fetch addr cleared", imem_addr, 32'd0);
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule